// File: doc/BRIEF.md
# Timer-Triggered Pulse Pattern Generator

This block drives a bank of 16 pulse output lines from a held pattern register. Software first loads a staging register with the next pattern. A strobe then arrives from a timer channel, either a compare match or an input capture. The block moves the staged bits into the pattern register, and that register drives the lines. The transfer happens in hardware at the exact cycle of the timer event, so the waveform edges do not depend on how quickly software responds.

The lines form four groups of four bits. Each group follows its own timer channel, chosen by a select field. A per-bit enable mask decides which bits take part in a transfer. A line that another peripheral owns is not driven by this block, but its pattern bit still updates. The block leaves reset in a stopped state. While stopped it ignores timer strobes and writes to every register except the stop bit.

Configuration uses a plain single-cycle register bus with a write strobe and a combinational read. There is no streamed data path, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `pulse_pattern_gen`

## Requirements
- R1: After reset the stop bit is 1 (read at address 4, bit 0), the pattern output is all zero, every output enable is 0, and every other register reads zero.
- R2: While the stop bit is 1, bus writes to addresses 0–3 have no effect, and reads of any address other than 4 return zero. A write to address 4 sets the stop bit to wdata bit 0 at any time.
- R3: While the stop bit is 1, timer strobes do not change the pattern register.
- R4: Group g covers bits 4g+3..4g. Its channel is the value of select-register bits 4g+3..4g (address 3). A strobe on that channel during cycle t copies the staged bits (address 0) into the pattern register at the clock edge that ends cycle t, and `pulse_out` shows the new value from then on.
- R5: Only bits whose enable (address 2) is 1 are updated by a transfer. All other bits keep their value.
- R6: If the staging register is written in the same cycle as a transfer, the staging value held before that write is the one transferred.
- R7: A transfer updates the pattern register even for lines flagged in `pin_taken`. `pulse_oe[i]` is 1 only when line i is not taken and the block is not stopped.
- R8: When `tmr_cap_mode[c]` is 1, channel c triggers only on `tmr_cap[c]` and ignores `tmr_cmp[c]`. When it is 0, the channel triggers only on `tmr_cmp[c]`.
- R9: The pattern register can be written at address 1. For bits that a transfer updates in the same cycle, the transfer wins over the write.
- R10: A select field whose value is N_CH or above selects no channel, and that group never transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 staging, 1 pattern, 2 enable, 3 select, 4 stop |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| tmr_cmp | input | N_CH | Compare-match strobes, one per channel |
| tmr_cap | input | N_CH | Input-capture strobes, one per channel |
| tmr_cap_mode | input | N_CH | 1 when the channel's A register is in capture mode |
| pin_taken | input | 16 | 1 when another peripheral owns the line |
| pulse_out | output | 16 | Pattern register value |
| pulse_oe | output | 16 | Output enable per line |

## Verification
The bench builds the block with N_CH = 3, keeping the 4-bit select fields. Select values 3 to 15 are then legal codes that name no channel, so the no-trigger path of R10 can be reached both by a directed case and by random select writes. The default 16-bit, four-group layout is kept, so per-group masking and transfers from several channels at once are exercised on the real pin count.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [2:0] {
    ADR_NEXT = 3'd0,
    ADR_OUT  = 3'd1,
    ADR_EN   = 3'd2,
    ADR_SEL  = 3'd3,
    ADR_STOP = 3'd4
  } ppg_addr_e;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_GRP  = 4,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [2:0]               addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        out_q,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        next_q,
  output logic [DATA_W-1:0]        en_q,
  output logic [N_GRP*SEL_W-1:0]   sel_q,
  output logic                     stop_q,
  output logic                     wr_out
);
  localparam int SELS_W = N_GRP * SEL_W;

  logic live_we;
  assign live_we = we && !stop_q;
  assign wr_out  = live_we && (addr == ADR_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q <= '0;
      en_q   <= '0;
      sel_q  <= '0;
      stop_q <= 1'b1;
    end else begin
      if (live_we && addr == ADR_NEXT) next_q <= wdata;
      if (live_we && addr == ADR_EN)   en_q   <= wdata;
      if (live_we && addr == ADR_SEL)  sel_q  <= wdata[SELS_W-1:0];
      if (we && addr == ADR_STOP)      stop_q <= wdata[0];
    end
  end

  logic [DATA_W-1:0] rd_raw;
  always_comb begin
    case (addr)
      ADR_NEXT: rd_raw = next_q;
      ADR_OUT:  rd_raw = out_q;
      ADR_EN:   rd_raw = en_q;
      ADR_SEL:  rd_raw = DATA_W'(sel_q);
      ADR_STOP: rd_raw = DATA_W'(stop_q);
      default:  rd_raw = '0;
    endcase
  end
  assign rdata = (stop_q && addr != ADR_STOP) ? '0 : rd_raw;

  // R2: a stopped block stays stopped unless the stop register is written
  assert_stop_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !(we && addr == ADR_STOP)) |=> stop_q);

  // R2: reads while stopped return zero
  assert_stopped_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && addr != ADR_STOP) |-> (rdata == '0));

  // R2: configuration is frozen while stopped
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> ($stable(next_q) && $stable(en_q) && $stable(sel_q)));
endmodule

// File: rtl/ppg_trig_sel.sv
module ppg_trig_sel #(
  parameter int N_CH  = 4,
  parameter int N_GRP = 4,
  parameter int SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        cmp,
  input  logic [N_CH-1:0]        cap,
  input  logic [N_CH-1:0]        cap_mode,
  input  logic [N_GRP*SEL_W-1:0] sel,
  output logic [N_GRP-1:0]       grp_trig
);
  logic [N_CH-1:0] chan_evt;
  assign chan_evt = (cap_mode & cap) | (~cap_mode & cmp);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [SEL_W-1:0] field;
    logic             hit;
    assign field = sel[g*SEL_W +: SEL_W];
    always_comb begin
      hit = 1'b0;
      for (int c = 0; c < N_CH; c++) begin
        if (field == SEL_W'(c)) hit = hit | chan_evt[c];
      end
    end
    assign grp_trig[g] = hit;

    // R10: an out-of-range select never produces a trigger
    assert_no_trig_out_of_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(32-SEL_W){1'b0}}, field} >= N_CH) |-> !grp_trig[g]);
  end

  // R8: with no strobes at all, no group triggers
  assert_quiet_no_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp == '0) && (cap == '0)) |-> (grp_trig == '0));
endmodule

// File: rtl/ppg_out_reg.sv
module ppg_out_reg #(
  parameter int DATA_W = 16,
  parameter int N_GRP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic [N_GRP-1:0]  grp_trig,
  input  logic [DATA_W-1:0] next_q,
  input  logic [DATA_W-1:0] en_q,
  input  logic              wr_out,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] out_q
);
  localparam int GRP_W = DATA_W / N_GRP;

  logic [DATA_W-1:0] xfer_mask;
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign xfer_mask[i] = grp_trig[i / GRP_W] & en_q[i];
  end

  logic [DATA_W-1:0] base;
  assign base = wr_out ? wdata : out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else if (!stop) out_q <= (base & ~xfer_mask) | (next_q & xfer_mask);
  end

  // R3: pattern frozen while stopped
  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(out_q));

  // R5: bits with enable low are not touched by transfers
  assert_disabled_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !wr_out) |=> (((out_q ^ $past(out_q)) & ~$past(en_q)) == '0));

  // R4: no strobe and no write leaves the pattern unchanged
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_trig == '0 && !wr_out) |=> $stable(out_q));
endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 16,
  parameter int N_GRP  = 4,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]   tmr_cmp,
  input  logic [N_CH-1:0]   tmr_cap,
  input  logic [N_CH-1:0]   tmr_cap_mode,
  input  logic [DATA_W-1:0] pin_taken,
  output logic [DATA_W-1:0] pulse_out,
  output logic [DATA_W-1:0] pulse_oe
);
  localparam int SELS_W = N_GRP * SEL_W;

  logic [DATA_W-1:0] next_q, en_q, out_q;
  logic [SELS_W-1:0] sel_q;
  logic              stop_q, wr_out;
  logic [N_GRP-1:0]  grp_trig;

  ppg_regs #(.DATA_W(DATA_W), .N_GRP(N_GRP), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .out_q(out_q), .rdata(reg_rdata), .next_q(next_q), .en_q(en_q),
    .sel_q(sel_q), .stop_q(stop_q), .wr_out(wr_out)
  );

  ppg_trig_sel #(.N_CH(N_CH), .N_GRP(N_GRP), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .cmp(tmr_cmp), .cap(tmr_cap),
    .cap_mode(tmr_cap_mode), .sel(sel_q), .grp_trig(grp_trig)
  );

  ppg_out_reg #(.DATA_W(DATA_W), .N_GRP(N_GRP)) u_out (
    .clk(clk), .rst_n(rst_n), .stop(stop_q), .grp_trig(grp_trig),
    .next_q(next_q), .en_q(en_q), .wr_out(wr_out), .wdata(reg_wdata),
    .out_q(out_q)
  );

  assign pulse_out = out_q;
  assign pulse_oe  = ~pin_taken & {DATA_W{~stop_q}};

  // R7: a line owned elsewhere is never driven, whatever the pattern
  assert_owned_not_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_oe & pin_taken) == '0));
endmodule

// File: tb/pulse_pattern_gen_bench.sv
`timescale 1ns/1ps
module pulse_pattern_gen_bench;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NCH-1:0] tmr_cmp = '0, tmr_cap = '0, tmr_cap_mode = '0;
  logic [15:0] pin_taken = '0;
  logic [15:0] pulse_out, pulse_oe;

  int total = 0;
  int bad = 0;

  logic [15:0] m_next, m_out, m_en, m_sel;
  logic        m_stop;

  always #2.5 clk = ~clk;

  pulse_pattern_gen #(.N_CH(NCH)) u_pulse_pattern_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_cmp(tmr_cmp),
    .tmr_cap(tmr_cap), .tmr_cap_mode(tmr_cap_mode), .pin_taken(pin_taken),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic grp_hit(logic [3:0] f, logic [NCH-1:0] cm,
                                   logic [NCH-1:0] cp, logic [NCH-1:0] md);
    if (f >= NCH) return 1'b0;
    return md[f] ? cp[f] : cm[f];
  endfunction

  function automatic logic [15:0] read_exp(logic [2:0] a);
    if (m_stop && a != 3'd4) return '0;
    case (a)
      3'd0: return m_next;
      3'd1: return m_out;
      3'd2: return m_en;
      3'd3: return m_sel;
      3'd4: return {15'd0, m_stop};
      default: return '0;
    endcase
  endfunction

  // One clock cycle with the given stimulus; the model advances and outputs are checked.
  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                      input logic [NCH-1:0] cm, input logic [NCH-1:0] cp,
                      input logic [NCH-1:0] md, input logic [15:0] tk, input string req);
    logic [15:0] mask, base, n_out, n_next, n_en, n_sel;
    logic n_stop;
    reg_we = we; reg_addr = a; reg_wdata = d;
    tmr_cmp = cm; tmr_cap = cp; tmr_cap_mode = md; pin_taken = tk;
    n_out = m_out; n_next = m_next; n_en = m_en; n_sel = m_sel; n_stop = m_stop;
    if (!m_stop) begin
      for (int i = 0; i < 16; i++)
        mask[i] = grp_hit(m_sel[(i/4)*4 +: 4], cm, cp, md) & m_en[i];
      base = (we && a == 3'd1) ? d : m_out;
      n_out = (base & ~mask) | (m_next & mask);
      if (we && a == 3'd0) n_next = d;
      if (we && a == 3'd2) n_en = d;
      if (we && a == 3'd3) n_sel = d;
    end
    if (we && a == 3'd4) n_stop = d[0];
    @(posedge clk);
    m_out = n_out; m_next = n_next; m_en = n_en; m_sel = n_sel; m_stop = n_stop;
    @(negedge clk);
    reg_we = 1'b0; tmr_cmp = '0; tmr_cap = '0;
    check(req, pulse_out, m_out);
    check("R7", pulse_oe, m_stop ? 16'h0 : ~tk);
  endtask

  task automatic peek(input logic [2:0] a, input string req);
    reg_we = 1'b0; reg_addr = a;
    #0.5;
    check(req, reg_rdata, read_exp(a));
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d, '0, '0, tmr_cap_mode, pin_taken, "R4");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7193));
    m_next = '0; m_out = '0; m_en = '0; m_sel = '0; m_stop = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", pulse_out, 16'h0);
    check("R1", pulse_oe, 16'h0);
    peek(3'd4, "R1");
    peek(3'd0, "R1");
    // R2/R3: stopped block ignores writes and strobes
    wr(3'd0, 16'hABCD);
    wr(3'd2, 16'hFFFF);
    peek(3'd0, "R2");
    step(1'b0, 3'd0, 16'h0, '1, '1, '0, 16'h0, "R3");
    wr(3'd4, 16'h0);
    peek(3'd0, "R2");
    peek(3'd2, "R2");
    // R4: basic transfer on channel 0
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h1234);
    step(1'b0, 3'd0, 16'h0, 3'b001, '0, '0, 16'h0, "R4");
    check("R4", pulse_out, 16'h1234);
    // R5: partial enable
    wr(3'd2, 16'h00F0);
    wr(3'd0, 16'hFFFF);
    step(1'b0, 3'd0, 16'h0, 3'b001, '0, '0, 16'h0, "R5");
    check("R5", pulse_out, 16'h12F4);
    // R6: staging write in the transfer cycle
    wr(3'd2, 16'hFFFF);
    wr(3'd0, 16'h5555);
    step(1'b1, 3'd0, 16'hAAAA, 3'b001, '0, '0, 16'h0, "R6");
    check("R6", pulse_out, 16'h5555);
    step(1'b0, 3'd0, 16'h0, 3'b001, '0, '0, 16'h0, "R6");
    check("R6", pulse_out, 16'hAAAA);
    // R7: transfer to owned lines
    wr(3'd0, 16'h0F0F);
    step(1'b0, 3'd0, 16'h0, 3'b001, '0, '0, 16'hFFFF, "R7");
    check("R7", pulse_out, 16'h0F0F);
    check("R7", pulse_oe, 16'h0000);
    // R8: capture mode selects the capture strobe
    wr(3'd0, 16'h6666);
    step(1'b0, 3'd0, 16'h0, 3'b001, '0, 3'b001, 16'h0, "R8");
    check("R8", pulse_out, 16'h0F0F);
    step(1'b0, 3'd0, 16'h0, '0, 3'b001, 3'b001, 16'h0, "R8");
    check("R8", pulse_out, 16'h6666);
    // R10 and per-group selection: groups 0..3 follow channels 0,1,2,3(none)
    wr(3'd3, 16'h3210);
    wr(3'd0, 16'h9999);
    step(1'b0, 3'd0, 16'h0, 3'b010, '0, '0, 16'h0, "R4");
    check("R4", pulse_out, 16'h6696);
    step(1'b0, 3'd0, 16'h0, 3'b111, '0, '0, 16'h0, "R10");
    check("R10", pulse_out, 16'h6999);
    // R9: transfer beats a same-cycle pattern write
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h000F);
    step(1'b1, 3'd1, 16'hFFFF, 3'b001, '0, '0, 16'h0, "R9");
    check("R9", pulse_out, 16'hFFF0);
    peek(3'd1, "R9");
    // Random traffic checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [15:0] d;
      logic w;
      a = 3'($urandom % 6);
      d = 16'($urandom);
      if (a == 3'd4) d[0] = (($urandom % 8) == 0);
      w = (($urandom % 3) == 0);
      step(w, a, d, NCH'($urandom), NCH'($urandom), NCH'($urandom),
           16'($urandom), "R4");
      if ((n % 7) == 0) peek(3'($urandom % 8), "R2");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule